// File: doc/BRIEF.md
# Interrupt Request Capture and Steering

This block turns raw interrupt request lines into per-source pending flags and forwards each pending request to one of two consumers: the processor interrupt line or the trigger line of a data-transfer engine. Six external pins each have a programmable trigger mode: low level, falling edge, rising edge or both edges. A set of on-chip peripheral sources each has a detection style fixed at build time: active-high level or rising edge.

An edge-detected flag is latched. It stays set until the consumer it is routed to accepts it, or until software writes 0 to it. A level-detected flag follows the synchronized input and cannot be cleared by any strobe. Each source has an enable bit and a destination bit. The two output lines are the registered OR of the enabled pending sources routed to each consumer.

Sources 0 to 5 are pins 0 to 5. Sources 6 upward are the peripheral inputs in index order. Priority arbitration and vector generation belong to the consumers.

Top module: `irq_route_top`

## Requirements
- R1: Pin i has a 2-bit mode in `pin_mode[2i+1:2i]`. The codes are 00 = active-low level, 01 = falling edge, 10 = rising edge and 11 = either edge. A transition that the mode does not select sets no flag.
- R2: Each pin passes through a two-flop synchronizer. A pin change that is present before clock edge k appears in `pend` after edge k+2, in both edge and level modes, and has not appeared after edge k+1.
- R3: In an edge mode the flag sets on the selected transition and stays set after the pin returns to its idle level.
- R4: In level mode the flag equals the synchronized active-low level, without latching. Acknowledges and software writes do not change it.
- R5: Peripheral source j uses bit j of parameter `PERI_LEVEL`: 1 means active-high level and 0 means rising edge. Peripheral inputs go through one register stage, so a change present before edge k appears in `pend` after edge k+1.
- R6: `src_dst[i]` = 0 routes source i to `cpu_irq`, and 1 routes it to `xfer_trig`. Each output rises one cycle after an enabled, routed flag is set. A flag routed to one consumer never drives the other.
- R7: When `src_en[i]` = 0, the flag of source i still sets but does not drive either output. Setting the enable bit forwards the flag one cycle later.
- R8: If `cpu_ack_vld` is high with `cpu_ack_id` = i and `src_dst[i]` = 0, the edge flag of source i clears at that edge. A processor acknowledge for a source routed to the transfer engine is ignored.
- R9: If `xfer_ack_vld` is high with `xfer_ack_id` = i and `src_dst[i]` = 1, the edge flag of source i clears at that edge.
- R10: If a new selected edge is detected in the same cycle as a clearing acknowledge, the flag stays set.
- R11: `sw_we[i]` with `sw_wd[i]` = 0 clears the edge flag of source i. A write with `sw_wd[i]` = 1 is ignored and never sets the flag.
- R12: While `rst` is high, all flags and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_PIN | Asynchronous external request pins |
| peri_in | input | N_PERI | On-chip peripheral request lines |
| pin_mode | input | 2*N_PIN | Trigger mode per pin, 2 bits each |
| src_en | input | N_SRC | Per-source forward enable |
| src_dst | input | N_SRC | Per-source destination (0 processor, 1 transfer engine) |
| cpu_ack_vld | input | 1 | Processor accepts an interrupt |
| cpu_ack_id | input | IDW | Source accepted by the processor |
| xfer_ack_vld | input | 1 | Transfer engine starts on a request |
| xfer_ack_id | input | IDW | Source the transfer engine started on |
| sw_we | input | N_SRC | Software write strobe per flag |
| sw_wd | input | N_SRC | Software write data per flag |
| pend | output | N_SRC | Pending flags |
| cpu_irq | output | 1 | Processor interrupt request |
| xfer_trig | output | 1 | Transfer engine trigger |

## Verification
Each pin is driven with rising, falling and round-trip transitions under every mode. This separates a mode that must react from one that must ignore the same transition, and separates latched edge flags from flags that follow the level. Acknowledges are sent on the matching destination, on the wrong destination and in the same cycle as a fresh edge. These cases separate a correct clear from an ignored one and from a lost request. Software writes of 0 and of 1 are sent to both edge and level flags. Peripheral sources of both fixed styles are pulsed so that the one-stage latency can be told apart from the two-stage pin latency.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    MODE_LOW  = 2'b00,
    MODE_FALL = 2'b01,
    MODE_RISE = 2'b10,
    MODE_BOTH = 2'b11
  } trig_mode_e;

  // Edge qualifier for a programmable pin
  function automatic logic pin_edge(trig_mode_e m, logic cur, logic old);
    case (m)
      MODE_FALL: return old & ~cur;
      MODE_RISE: return cur & ~old;
      MODE_BOTH: return cur ^ old;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import irq_route_pkg::*;
#(
  parameter int              N_PIN      = 6,
  parameter int              N_PERI     = 4,
  parameter logic [N_PERI-1:0] PERI_LEVEL = '0,
  localparam int             N_SRC      = N_PIN + N_PERI
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   smp,
  input  logic [2*N_PIN-1:0] pin_mode,
  output logic [N_SRC-1:0]   edge_hit,
  output logic [N_SRC-1:0]   lvl_sel,
  output logic [N_SRC-1:0]   lvl_act
);

  logic [N_SRC-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= smp;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i < N_PIN) begin : g_pin
      trig_mode_e m;
      assign m           = trig_mode_e'(pin_mode[2*i +: 2]);
      assign lvl_sel[i]  = (m == MODE_LOW);
      assign lvl_act[i]  = ~smp[i];
      assign edge_hit[i] = pin_edge(m, smp[i], prev[i]);
    end else begin : g_peri
      localparam bit IS_LVL = PERI_LEVEL[i-N_PIN];
      assign lvl_sel[i]  = IS_LVL;
      assign lvl_act[i]  = smp[i];
      assign edge_hit[i] = !IS_LVL && smp[i] && !prev[i];
    end
  end

endmodule

// File: rtl/irq_flag.sv
module irq_flag #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] edge_hit,
  input  logic [N-1:0] lvl_sel,
  input  logic [N-1:0] lvl_act,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (lvl_sel[i])       pend[i] <= lvl_act[i];
        else if (edge_hit[i]) pend[i] <= 1'b1;
        else if (clr[i])      pend[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_steer.sv
module irq_steer #(
  parameter int N   = 10,
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   pend,
  input  logic [N-1:0]   src_en,
  input  logic [N-1:0]   src_dst,
  input  logic           cpu_ack_vld,
  input  logic [IDW-1:0] cpu_ack_id,
  input  logic           xfer_ack_vld,
  input  logic [IDW-1:0] xfer_ack_id,
  input  logic [N-1:0]   sw_we,
  input  logic [N-1:0]   sw_wd,
  output logic [N-1:0]   clr,
  output logic           cpu_irq,
  output logic           xfer_trig
);

  logic [N-1:0] cpu_take;
  logic [N-1:0] xfer_take;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign cpu_take[i]  = cpu_ack_vld  && (cpu_ack_id  == IDW'(i)) && !src_dst[i];
    assign xfer_take[i] = xfer_ack_vld && (xfer_ack_id == IDW'(i)) &&  src_dst[i];
  end

  assign clr = cpu_take | xfer_take | (sw_we & ~sw_wd);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq   <= 1'b0;
      xfer_trig <= 1'b0;
    end else begin
      cpu_irq   <= |(pend & src_en & ~src_dst);
      xfer_trig <= |(pend & src_en &  src_dst);
    end
  end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
  parameter int                N_PIN      = 6,
  parameter int                N_PERI     = 4,
  parameter int                PIN_SYNC   = 2,
  parameter logic [N_PERI-1:0] PERI_LEVEL = 4'b1010,
  localparam int               N_SRC      = N_PIN + N_PERI,
  localparam int               IDW        = $clog2(N_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PIN-1:0]   pin_in,
  input  logic [N_PERI-1:0]  peri_in,
  input  logic [2*N_PIN-1:0] pin_mode,
  input  logic [N_SRC-1:0]   src_en,
  input  logic [N_SRC-1:0]   src_dst,
  input  logic               cpu_ack_vld,
  input  logic [IDW-1:0]     cpu_ack_id,
  input  logic               xfer_ack_vld,
  input  logic [IDW-1:0]     xfer_ack_id,
  input  logic [N_SRC-1:0]   sw_we,
  input  logic [N_SRC-1:0]   sw_wd,
  output logic [N_SRC-1:0]   pend,
  output logic               cpu_irq,
  output logic               xfer_trig
);

  logic [N_PIN-1:0]  pin_s;
  logic [N_PERI-1:0] peri_s;
  logic [N_SRC-1:0]  edge_hit;
  logic [N_SRC-1:0]  lvl_sel;
  logic [N_SRC-1:0]  lvl_act;
  logic [N_SRC-1:0]  clr;

  irq_sync #(.W(N_PIN), .STAGES(PIN_SYNC)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  irq_sync #(.W(N_PERI), .STAGES(1)) u_peri_reg (
    .clk(clk), .rst(rst), .d(peri_in), .q(peri_s)
  );

  irq_detect #(.N_PIN(N_PIN), .N_PERI(N_PERI), .PERI_LEVEL(PERI_LEVEL)) u_detect (
    .clk(clk), .rst(rst), .smp({peri_s, pin_s}), .pin_mode(pin_mode),
    .edge_hit(edge_hit), .lvl_sel(lvl_sel), .lvl_act(lvl_act)
  );

  irq_flag #(.N(N_SRC)) u_flag (
    .clk(clk), .rst(rst), .edge_hit(edge_hit), .lvl_sel(lvl_sel),
    .lvl_act(lvl_act), .clr(clr), .pend(pend)
  );

  irq_steer #(.N(N_SRC), .IDW(IDW)) u_steer (
    .clk(clk), .rst(rst), .pend(pend), .src_en(src_en), .src_dst(src_dst),
    .cpu_ack_vld(cpu_ack_vld), .cpu_ack_id(cpu_ack_id),
    .xfer_ack_vld(xfer_ack_vld), .xfer_ack_id(xfer_ack_id),
    .sw_we(sw_we), .sw_wd(sw_wd), .clr(clr),
    .cpu_irq(cpu_irq), .xfer_trig(xfer_trig)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int N_SRC = 10,
  parameter int IDW   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] pend,
  input logic             cpu_irq,
  input logic             xfer_trig,
  input logic [N_SRC-1:0] src_en,
  input logic [N_SRC-1:0] src_dst,
  input logic             cpu_ack_vld,
  input logic [IDW-1:0]   cpu_ack_id,
  input logic             xfer_ack_vld,
  input logic [IDW-1:0]   xfer_ack_id,
  input logic [N_SRC-1:0] edge_hit,
  input logic [N_SRC-1:0] lvl_sel,
  input logic [N_SRC-1:0] lvl_act
);

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  logic cpu_ok, xfer_ok;
  assign cpu_ok  = {1'b0, cpu_ack_id}  < (IDW+1)'(N_SRC);
  assign xfer_ok = {1'b0, xfer_ack_id} < (IDW+1)'(N_SRC);

  p_edge_sets_r3: assert property (@(posedge clk) disable iff (rst)
    armed && |(edge_hit & ~lvl_sel) |=> (($past(edge_hit & ~lvl_sel) & ~pend) == '0));

  p_level_follow_r4: assert property (@(posedge clk) disable iff (rst)
    armed |=> ((($past(lvl_act) ^ pend) & $past(lvl_sel)) == '0));

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    armed && (src_en == '0) |=> (!cpu_irq && !xfer_trig));

  p_cpu_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
    armed && cpu_ack_vld && cpu_ok && !src_dst[cpu_ack_id] && !lvl_sel[cpu_ack_id]
    && !edge_hit[cpu_ack_id] |=> !pend[$past(cpu_ack_id)]);

  p_xfer_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    armed && xfer_ack_vld && xfer_ok && src_dst[xfer_ack_id] && !lvl_sel[xfer_ack_id]
    && !edge_hit[xfer_ack_id] |=> !pend[$past(xfer_ack_id)]);

  p_edge_beats_ack_r10: assert property (@(posedge clk) disable iff (rst)
    armed && cpu_ack_vld && cpu_ok && !lvl_sel[cpu_ack_id] && edge_hit[cpu_ack_id]
    |=> pend[$past(cpu_ack_id)]);

endmodule

bind irq_route_top irq_route_chk #(.N_SRC(N_SRC), .IDW(IDW)) i_irq_route_chk (
  .clk(clk), .rst(rst), .pend(pend), .cpu_irq(cpu_irq), .xfer_trig(xfer_trig),
  .src_en(src_en), .src_dst(src_dst),
  .cpu_ack_vld(cpu_ack_vld), .cpu_ack_id(cpu_ack_id),
  .xfer_ack_vld(xfer_ack_vld), .xfer_ack_id(xfer_ack_id),
  .edge_hit(edge_hit), .lvl_sel(lvl_sel), .lvl_act(lvl_act)
);

// File: tb/test_irq_route_top.sv
module test_irq_route_top;

  localparam int N_PIN = 6;
  localparam int N_PERI = 4;
  localparam int N_SRC = 10;
  localparam int IDW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_PIN-1:0]   pin_in = '0;
  logic [N_PERI-1:0]  peri_in = '0;
  logic [2*N_PIN-1:0] pin_mode = {N_PIN{2'b10}};
  logic [N_SRC-1:0]   src_en = '1;
  logic [N_SRC-1:0]   src_dst = '0;
  logic               cpu_ack_vld = 1'b0;
  logic [IDW-1:0]     cpu_ack_id = '0;
  logic               xfer_ack_vld = 1'b0;
  logic [IDW-1:0]     xfer_ack_id = '0;
  logic [N_SRC-1:0]   sw_we = '0;
  logic [N_SRC-1:0]   sw_wd = '0;
  logic [N_SRC-1:0]   pend;
  logic               cpu_irq;
  logic               xfer_trig;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_route_top #(.N_PIN(N_PIN), .N_PERI(N_PERI), .PERI_LEVEL(4'b1010)) i_irq_route_top (
    .clk(clk), .rst(rst), .pin_in(pin_in), .peri_in(peri_in), .pin_mode(pin_mode),
    .src_en(src_en), .src_dst(src_dst), .cpu_ack_vld(cpu_ack_vld), .cpu_ack_id(cpu_ack_id),
    .xfer_ack_vld(xfer_ack_vld), .xfer_ack_id(xfer_ack_id), .sw_we(sw_we), .sw_wd(sw_wd),
    .pend(pend), .cpu_irq(cpu_irq), .xfer_trig(xfer_trig)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpu_ack(int id);
    cpu_ack_vld = 1'b1; cpu_ack_id = IDW'(id);
    tick(1);
    cpu_ack_vld = 1'b0;
  endtask

  task automatic sw_write(int id, logic val);
    sw_we[id] = 1'b1; sw_wd[id] = val;
    tick(1);
    sw_we[id] = 1'b0; sw_wd[id] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 pend after reset", 32'(pend), 0);
    chk("R12 cpu_irq after reset", 32'(cpu_irq), 0);
    chk("R12 xfer_trig after reset", 32'(xfer_trig), 0);
  endtask

  task automatic t_rise_pin;
    pin_in[0] = 1'b1;
    tick(2); chk("R2 pin0 not yet after two edges", 32'(pend[0]), 0);
    tick(1); chk("R1 rising sets pin0", 32'(pend[0]), 1);
    chk("R6 cpu_irq one cycle later", 32'(cpu_irq), 0);
    tick(1); chk("R6 cpu_irq raised", 32'(cpu_irq), 1);
    chk("R6 no xfer_trig for cpu route", 32'(xfer_trig), 0);
    pin_in[0] = 1'b0;
    tick(4); chk("R3 pin0 latched after release", 32'(pend[0]), 1);
    cpu_ack(0); chk("R8 cpu ack clears pin0", 32'(pend[0]), 0);
    tick(1); chk("R8 cpu_irq drops", 32'(cpu_irq), 0);
  endtask

  task automatic t_fall_pin;
    pin_mode[3:2] = 2'b01;
    pin_in[1] = 1'b1;
    tick(4); chk("R1 falling mode ignores rise", 32'(pend[1]), 0);
    pin_in[1] = 1'b0;
    tick(3); chk("R1 falling mode sets", 32'(pend[1]), 1);
    sw_write(1, 1'b0); chk("R11 write 0 clears pin1", 32'(pend[1]), 0);
  endtask

  task automatic t_both_pin;
    pin_mode[5:4] = 2'b11;
    pin_in[2] = 1'b1;
    tick(3); chk("R1 both mode on rise", 32'(pend[2]), 1);
    sw_write(2, 1'b0);
    chk("R11 clear pin2", 32'(pend[2]), 0);
    pin_in[2] = 1'b0;
    tick(3); chk("R1 both mode on fall", 32'(pend[2]), 1);
    sw_write(2, 1'b0);
  endtask

  task automatic t_level_pin;
    pin_mode[7:6] = 2'b01;
    pin_in[3] = 1'b1;
    tick(4);
    pin_mode[7:6] = 2'b00;
    tick(1); chk("R4 level high is inactive", 32'(pend[3]), 0);
    pin_in[3] = 1'b0;
    tick(2); chk("R2 level not yet after two edges", 32'(pend[3]), 0);
    tick(1); chk("R4 level low sets", 32'(pend[3]), 1);
    sw_we[3] = 1'b1; sw_wd[3] = 1'b0;
    cpu_ack_vld = 1'b1; cpu_ack_id = 4'd3;
    tick(1);
    sw_we[3] = 1'b0; cpu_ack_vld = 1'b0;
    chk("R4 level ignores ack and write", 32'(pend[3]), 1);
    pin_in[3] = 1'b1;
    tick(3); chk("R4 level follows release", 32'(pend[3]), 0);
    pin_mode[7:6] = 2'b01;
    tick(1);
  endtask

  task automatic t_write_one;
    sw_write(4, 1'b1); chk("R11 write 1 does not set", 32'(pend[4]), 0);
    pin_in[4] = 1'b1;
    tick(3); chk("R1 pin4 rising", 32'(pend[4]), 1);
    sw_write(4, 1'b1); chk("R11 write 1 does not clear", 32'(pend[4]), 1);
    pin_in[4] = 1'b0;
    sw_write(4, 1'b0); chk("R11 write 0 clears pin4", 32'(pend[4]), 0);
  endtask

  task automatic t_xfer;
    src_dst[5] = 1'b1;
    pin_in[5] = 1'b1;
    tick(3); chk("R6 pin5 pending", 32'(pend[5]), 1);
    tick(1); chk("R6 xfer_trig raised", 32'(xfer_trig), 1);
    chk("R6 cpu_irq stays low", 32'(cpu_irq), 0);
    cpu_ack(5); chk("R8 cpu ack ignored for xfer route", 32'(pend[5]), 1);
    xfer_ack_vld = 1'b1; xfer_ack_id = 4'd5;
    tick(1);
    xfer_ack_vld = 1'b0;
    chk("R9 xfer ack clears", 32'(pend[5]), 0);
    tick(1); chk("R9 xfer_trig drops", 32'(xfer_trig), 0);
    pin_in[5] = 1'b0;
    src_dst[5] = 1'b0;
    tick(1);
  endtask

  task automatic t_enable;
    src_en[0] = 1'b0;
    pin_in[0] = 1'b1;
    tick(4); chk("R7 flag sets while disabled", 32'(pend[0]), 1);
    chk("R7 disabled keeps cpu_irq low", 32'(cpu_irq), 0);
    src_en[0] = 1'b1;
    tick(1); chk("R7 enable forwards", 32'(cpu_irq), 1);
    cpu_ack(0);
    pin_in[0] = 1'b0;
    tick(3);
  endtask

  task automatic t_coincide;
    pin_in[0] = 1'b1;
    tick(2);
    cpu_ack(0); chk("R10 edge with ack keeps flag", 32'(pend[0]), 1);
    cpu_ack(0); chk("R8 later ack clears", 32'(pend[0]), 0);
    pin_in[0] = 1'b0;
    tick(3);
  endtask

  task automatic t_peri;
    peri_in[0] = 1'b1;
    tick(1); chk("R5 peri edge not yet", 32'(pend[6]), 0);
    tick(1); chk("R5 peri edge sets", 32'(pend[6]), 1);
    peri_in[0] = 1'b0;
    tick(2); chk("R5 peri edge latched", 32'(pend[6]), 1);
    sw_write(6, 1'b0); chk("R11 clear peri edge", 32'(pend[6]), 0);
    src_dst[7] = 1'b1;
    peri_in[1] = 1'b1;
    tick(2); chk("R5 peri level sets", 32'(pend[7]), 1);
    tick(1); chk("R6 peri level to xfer", 32'(xfer_trig), 1);
    peri_in[1] = 1'b0;
    tick(2); chk("R5 peri level follows", 32'(pend[7]), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    tick(2);
    t_rise_pin();
    t_fall_pin();
    t_both_pin();
    t_level_pin();
    t_write_one();
    t_xfer();
    t_enable();
    t_coincide();
    t_peri();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule